// File: doc/BRIEF.md
# Segment-Erase Flash Program Controller

This block sequences program and erase operations on a small on-chip array that behaves like nonvolatile storage and is modelled here as registers. Software configures it through a keyed control port: every control write carries an 8-bit key in its upper byte, and a write with the wrong key is dropped and flagged. At reset the array is locked. Software must unlock it, choose an operation mode and set a timing divider before any program or erase is accepted.

With a program or erase mode selected, a write to the array starts the operation. Programming can only clear bits, so the stored byte becomes the old contents ANDed with the new data. A write to any address inside a segment erases that whole segment to all-ones. Mass erase does the same to every main segment and leaves the information segments alone. The operation runs from a timing generator that divides the system clock. A busy output stays high for a fixed number of generator periods. If the divided rate would fall outside 257 to 476 kHz, the operation is aborted and a fail flag is raised.

In read mode, or whenever the array is idle, a read returns one aligned 16-bit word one cycle later. Access errors are recorded in sticky flags that software clears with a keyed write.

Top module: `flash_prog_ctl`

## Requirements
- R1: After reset the array is locked, busy, fail, viol and key_err are low, every array byte holds 0xFF, the divider is 0 and the mode is read.
- R2: A control write whose wdata[15:8] differs from 0xA5 changes no register and sets key_err. Selects are 0 mode, 1 divider, 2 lock and 3 flag clear, and the payload sits in wdata[7:0].
- R3: Lock is payload bit 0 of select 2. While the array is locked, an array write sets viol and leaves the array unchanged. Reads still work while locked.
- R4: The mode payload bits are bit0 byte/word write, bit1 block write, bit2 segment erase and bit3 mass erase. Priority runs mass erase, then segment erase, then block write, then write. With no bit set the mode is read, and an array write in read mode sets viol and changes nothing.
- R5: In a write or block-write operation the target becomes old AND data. When arr_wide is 0 this is the byte at arr_addr, taking data[7:0]. When arr_wide is 1 it is the word at arr_addr with bit 0 forced to 0: data[7:0] goes to the even byte and data[15:8] to the odd byte.
- R6: A segment erase sets every byte of the segment holding arr_addr to 0xFF and leaves all other bytes unchanged. Layout: INFO_SEGS segments of INFO_BYTES from address 0, then MAIN_SEGS segments of MAIN_BYTES.
- R7: A mass erase sets every byte of every main segment to 0xFF and leaves the information segments unchanged.
- R8: An accepted operation raises busy on the next cycle. Busy then stays high for exactly T*n cycles, where n = divider+1 and T is WRITE_TICKS, BLOCK_TICKS or ERASE_TICKS. Array contents change only in the cycle busy falls.
- R9: An operation is accepted only if CLK_KHZ/n lies within [257, 476] inclusive. Otherwise the start sets fail, busy stays low and the array is unchanged.
- R10: While busy, an array write or read sets viol and is ignored: the array and arr_rdata are unchanged. Control writes are ignored without setting key_err.
- R11: A read with arr_re while idle loads arr_rdata on the next cycle with {byte[a|1], byte[a with bit0 = 0]}.
- R12: A keyed write to select 3 clears fail, viol and key_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the source of the timing generator |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_sel | input | 2 | Control register select |
| ctl_wdata | input | 16 | Key in [15:8], payload in [7:0] |
| arr_we | input | 1 | Array write (program data or erase trigger) |
| arr_re | input | 1 | Array read request |
| arr_wide | input | 1 | 1 = 16-bit word write, 0 = byte write |
| arr_addr | input | ADDR_W | Byte address into the array |
| arr_wdata | input | 16 | Write data |
| arr_rdata | output | 16 | Read word, valid the cycle after arr_re |
| busy | output | 1 | Operation in progress |
| locked | output | 1 | Array lock state |
| fail | output | 1 | Sticky: start refused because of the timing rate |
| viol | output | 1 | Sticky: array access refused |
| key_err | output | 1 | Sticky: control write carried a wrong key |

## Verification
The assertions assume that rst_n is held low for at least one clock edge and that the divider field only changes through keyed control writes. They also assume that arr_addr stays below the array size, because an address past the end selects no segment. The bench drives every input at the falling edge. It only issues addresses inside its small array and only uses even addresses for reads. Its divider sweep covers every value of the field, so each legal and illegal rate goes through the start logic.

// File: rtl/flash_pkg.sv
`timescale 1ns/1ps
package flash_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_BLOCK = 3'd2,
    OP_SEG   = 3'd3,
    OP_MASS  = 3'd4
  } op_e;

  localparam logic [7:0] CTL_KEY   = 8'hA5;
  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_DIV   = 2'd1;
  localparam logic [1:0] SEL_LOCK  = 2'd2;
  localparam logic [1:0] SEL_FLAGS = 2'd3;
  localparam int unsigned RATE_MIN_KHZ = 257;
  localparam int unsigned RATE_MAX_KHZ = 476;

  // Highest-priority mode bit wins.
  function automatic op_e decode_mode(input logic [3:0] m);
    op_e r;
    if (m[3])      r = OP_MASS;
    else if (m[2]) r = OP_SEG;
    else if (m[1]) r = OP_BLOCK;
    else if (m[0]) r = OP_WRITE;
    else           r = OP_READ;
    return r;
  endfunction

  // clk_khz / n inside the window, done without division.
  function automatic logic rate_legal(input int unsigned n, input int unsigned clk_khz);
    return (n * RATE_MIN_KHZ <= clk_khz) && (n * RATE_MAX_KHZ >= clk_khz);
  endfunction

  // Segment number of a byte address: info segments first, then main.
  function automatic int unsigned seg_of(input int unsigned a, input int unsigned info_segs,
                                         input int unsigned info_bytes, input int unsigned main_bytes);
    int unsigned r;
    if (a < info_segs * info_bytes) r = a / info_bytes;
    else r = info_segs + (a - info_segs * info_bytes) / main_bytes;
    return r;
  endfunction

endpackage

// File: rtl/flash_regs.sv
`timescale 1ns/1ps
module flash_regs #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_sel,
  input  logic [15:0]      ctl_wdata,
  input  logic             busy,
  output logic [3:0]       mode_q,
  output logic [DIV_W-1:0] div_q,
  output logic             locked,
  output logic             key_err,
  output logic             flag_clr
);
  import flash_pkg::*;

  logic key_ok, accept, bad_key;
  logic [7:0] payload;

  assign payload  = ctl_wdata[7:0];
  assign key_ok   = (ctl_wdata[15:8] == CTL_KEY);
  assign accept   = ctl_we && !busy && key_ok;
  assign bad_key  = ctl_we && !busy && !key_ok;
  assign flag_clr = accept && (ctl_sel == SEL_FLAGS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      div_q   <= '0;
      locked  <= 1'b1;
      key_err <= 1'b0;
    end else begin
      if (accept && ctl_sel == SEL_MODE) mode_q <= payload[3:0];
      if (accept && ctl_sel == SEL_DIV)  div_q  <= payload[DIV_W-1:0];
      if (accept && ctl_sel == SEL_LOCK) locked <= payload[0];
      key_err <= (key_err && !flag_clr) || bad_key;
    end
  end
endmodule

// File: rtl/flash_tgen.sv
`timescale 1ns/1ps
module flash_tgen #(
  parameter int DIV_W   = 6,
  parameter int CLK_KHZ = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             div_ok
);
  import flash_pkg::*;

  logic [DIV_W-1:0] pre;

  assign tick   = run && (pre == div);
  assign div_ok = rate_legal(int'(unsigned'(div)) + 1, CLK_KHZ);

  always_ff @(posedge clk) begin
    if (!rst_n)       pre <= '0;
    else if (restart) pre <= '0;
    else if (run)     pre <= tick ? '0 : pre + 1'b1;
  end
endmodule

// File: rtl/flash_seq.sv
`timescale 1ns/1ps
module flash_seq #(
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] ticks_req,
  input  logic          tick,
  output logic          busy,
  output logic          done
);
  logic [TW-1:0] rem;

  assign done = busy && tick && (rem == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rem  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      rem  <= ticks_req;
    end else if (busy && tick) begin
      rem <= rem - 1'b1;
      if (done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_prog_ctl.sv
`timescale 1ns/1ps
module flash_prog_ctl #(
  parameter int CLK_KHZ     = 4000,
  parameter int DIV_W       = 6,
  parameter int INFO_SEGS   = 2,
  parameter int INFO_BYTES  = 128,
  parameter int MAIN_SEGS   = 2,
  parameter int MAIN_BYTES  = 512,
  parameter int WRITE_TICKS = 35,
  parameter int BLOCK_TICKS = 25,
  parameter int ERASE_TICKS = 4819,
  parameter int ADDR_W      = $clog2(INFO_SEGS*INFO_BYTES + MAIN_SEGS*MAIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_sel,
  input  logic [15:0]       ctl_wdata,
  input  logic              arr_we,
  input  logic              arr_re,
  input  logic              arr_wide,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [15:0]       arr_wdata,
  output logic [15:0]       arr_rdata,
  output logic              busy,
  output logic              locked,
  output logic              fail,
  output logic              viol,
  output logic              key_err
);
  import flash_pkg::*;

  localparam int INFO_TOTAL = INFO_SEGS * INFO_BYTES;
  localparam int TOTAL      = INFO_TOTAL + MAIN_SEGS * MAIN_BYTES;
  localparam int MAX_TICKS  = (ERASE_TICKS > WRITE_TICKS) ? ERASE_TICKS : WRITE_TICKS;
  localparam int TW         = $clog2(MAX_TICKS + 1);

  logic [7:0]        mem [TOTAL];
  logic [3:0]        mode_q;
  logic [DIV_W-1:0]  div_q;
  logic              flag_clr, tick, div_ok, op_done;
  logic              start_req, start_ok, start_bad, wr_reject, rd_reject, acc_viol;
  op_e               cur_op, pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [15:0]       pend_data;
  logic              pend_wide;
  logic [TW-1:0]     ticks_req;
  int unsigned       tgt_seg;
  logic [ADDR_W-1:0] lo_idx, hi_idx;

  flash_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .busy(busy), .mode_q(mode_q), .div_q(div_q), .locked(locked), .key_err(key_err),
    .flag_clr(flag_clr)
  );

  flash_tgen #(.DIV_W(DIV_W), .CLK_KHZ(CLK_KHZ)) u_tgen (
    .clk(clk), .rst_n(rst_n), .restart(start_ok), .run(busy), .div(div_q),
    .tick(tick), .div_ok(div_ok)
  );

  flash_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .ticks_req(ticks_req), .tick(tick),
    .busy(busy), .done(op_done)
  );

  // Access decisions
  assign cur_op    = decode_mode(mode_q);
  assign wr_reject = arr_we && (busy || locked || cur_op == OP_READ);
  assign start_req = arr_we && !busy && !locked && cur_op != OP_READ;
  assign start_ok  = start_req && div_ok;
  assign start_bad = start_req && !div_ok;
  assign rd_reject = arr_re && busy;
  assign acc_viol  = wr_reject || rd_reject;

  always_comb begin
    case (cur_op)
      OP_WRITE:        ticks_req = TW'(WRITE_TICKS);
      OP_BLOCK:        ticks_req = TW'(BLOCK_TICKS);
      OP_SEG, OP_MASS: ticks_req = TW'(ERASE_TICKS);
      default:         ticks_req = '0;
    endcase
  end

  // Operation captured at start, committed when busy falls
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_op   <= OP_READ;
      pend_addr <= '0;
      pend_data <= '0;
      pend_wide <= 1'b0;
    end else if (start_ok) begin
      pend_op   <= cur_op;
      pend_addr <= arr_addr;
      pend_data <= arr_wdata;
      pend_wide <= arr_wide;
    end
  end

  assign tgt_seg = seg_of(int'(unsigned'(pend_addr)), INFO_SEGS, INFO_BYTES, MAIN_BYTES);
  assign lo_idx  = {pend_addr[ADDR_W-1:1], 1'b0};
  assign hi_idx  = {pend_addr[ADDR_W-1:1], 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= 8'hFF;
    end else if (op_done) begin
      for (int i = 0; i < TOTAL; i++) begin
        case (pend_op)
          OP_WRITE, OP_BLOCK: begin
            if (!pend_wide && ADDR_W'(i) == pend_addr)
              mem[i] <= mem[i] & pend_data[7:0];
            if (pend_wide && ADDR_W'(i) == lo_idx)
              mem[i] <= mem[i] & pend_data[7:0];
            if (pend_wide && ADDR_W'(i) == hi_idx)
              mem[i] <= mem[i] & pend_data[15:8];
          end
          OP_SEG:
            if (seg_of(i, INFO_SEGS, INFO_BYTES, MAIN_BYTES) == tgt_seg) mem[i] <= 8'hFF;
          OP_MASS:
            if (i >= INFO_TOTAL) mem[i] <= 8'hFF;
          default: ;
        endcase
      end
    end
  end

  // Read port and sticky flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr_rdata <= '0;
      fail      <= 1'b0;
      viol      <= 1'b0;
    end else begin
      if (arr_re && !busy)
        arr_rdata <= {mem[{arr_addr[ADDR_W-1:1], 1'b1}], mem[{arr_addr[ADDR_W-1:1], 1'b0}]};
      fail <= (fail && !flag_clr) || start_bad;
      viol <= (viol && !flag_clr) || acc_viol;
    end
  end
endmodule

// File: rtl/flash_prog_chk.sv
`timescale 1ns/1ps
module flash_prog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_ok,
  input logic       start_bad,
  input logic       op_done,
  input logic       busy,
  input logic       fail,
  input logic       viol,
  input logic       locked,
  input logic       flag_clr,
  input logic [3:0] mode_q
);
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy); // R8
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !busy); // R8
  AST_BAD_RATE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (fail && !busy)); // R9
  AST_LOCKED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !start_ok); // R3
  AST_READ_MODE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 4'd0) |-> !start_ok); // R4
  AST_MODE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q)); // R10
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !flag_clr) |=> viol); // R12
endmodule

bind flash_prog_ctl flash_prog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .start_bad(start_bad), .op_done(op_done),
  .busy(busy), .fail(fail), .viol(viol), .locked(locked), .flag_clr(flag_clr), .mode_q(mode_q)
);

// File: tb/flash_prog_ctl_test.sv
`timescale 1ns/1ps
module flash_prog_ctl_test;
  localparam int CLK_KHZ = 4000;
  localparam int IS = 2, IB = 8, MS = 2, MB = 16;
  localparam int TOT = IS*IB + MS*MB;
  localparam int AW = $clog2(TOT);
  localparam int WT = 3, BT = 2, ET = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, arr_we = 0, arr_re = 0, arr_wide = 0;
  logic [1:0] ctl_sel = 0;
  logic [15:0] ctl_wdata = 0, arr_wdata = 0, arr_rdata;
  logic [AW-1:0] arr_addr = 0;
  logic busy, locked, fail, viol, key_err;

  int checks = 0, errors = 0;
  logic [7:0] model [TOT];

  always #4 clk = ~clk;

  flash_prog_ctl #(.CLK_KHZ(CLK_KHZ), .DIV_W(6), .INFO_SEGS(IS), .INFO_BYTES(IB),
    .MAIN_SEGS(MS), .MAIN_BYTES(MB), .WRITE_TICKS(WT), .BLOCK_TICKS(BT), .ERASE_TICKS(ET)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .arr_we(arr_we), .arr_re(arr_re), .arr_wide(arr_wide), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .busy(busy), .locked(locked),
    .fail(fail), .viol(viol), .key_err(key_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_raw(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); ctl_we = 1; ctl_sel = sel; ctl_wdata = d;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic ctl(input logic [1:0] sel, input logic [7:0] p);
    ctl_raw(sel, {8'hA5, p});
  endtask

  task automatic awrite(input int a, input logic [15:0] d, input logic w);
    @(negedge clk); arr_we = 1; arr_addr = AW'(a); arr_wdata = d; arr_wide = w;
    @(negedge clk); arr_we = 0;
  endtask

  task automatic aread(input int a, output logic [15:0] v);
    @(negedge clk); arr_re = 1; arr_addr = AW'(a);
    @(negedge clk); arr_re = 0; v = arr_rdata;
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
  endtask

  task automatic check_all(input string req);
    logic [15:0] v;
    for (int a = 0; a < TOT; a += 2) begin
      aread(a, v);
      chk(req, v, {model[a+1], model[a]});
    end
  endtask

  task automatic prog(input int a, input logic [15:0] d, input logic w);
    if (w) begin
      model[a & ~1] &= d[7:0];
      model[a | 1]  &= d[15:8];
    end else model[a] &= d[7:0];
  endtask

  function automatic int segno(input int a);
    return (a < IS*IB) ? a / IB : IS + (a - IS*IB) / MB;
  endfunction

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    logic [15:0] v, prev;
    for (int i = 0; i < TOT; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 locked", locked, 1); chk("R1 busy", busy, 0);
    chk("R1 flags", {fail, viol, key_err}, 0);
    check_all("R1/R11 erased readback");

    // R3 write while locked
    ctl(2'd0, 8'h01); ctl(2'd1, 8'd8);
    awrite(4, 16'h0000, 1);
    chk("R3 viol on locked write", viol, 1); chk("R3 no busy", busy, 0);
    check_all("R3 array unchanged");
    ctl(2'd3, 8'h00);
    chk("R12 flags cleared", {fail, viol, key_err}, 0);

    // R2 wrong key
    ctl_raw(2'd2, 16'h5A00);
    chk("R2 key_err", key_err, 1); chk("R2 lock kept", locked, 1);
    ctl(2'd3, 8'h00);
    chk("R12 key_err cleared", key_err, 0);

    // R4 read mode rejects writes
    ctl(2'd2, 8'h00); chk("R3 unlocked", locked, 0);
    ctl(2'd0, 8'h00);
    awrite(6, 16'h0000, 1);
    chk("R4 read-mode viol", viol, 1); chk("R4 read-mode no busy", busy, 0);
    check_all("R4 array unchanged");
    ctl(2'd3, 8'h00);

    // R9 divider sweep with byte writes, R8 durations, R5 AND
    ctl(2'd0, 8'h01);
    for (int n = 1; n <= 64; n++) begin
      real f;
      logic legal;
      int a;
      logic [7:0] d;
      f = 4000.0 / n;
      legal = (f >= 257.0) && (f <= 476.0);
      a = n % TOT;
      d = 8'hFF ^ (8'h01 << (n % 8));
      ctl(2'd1, 8'(n - 1));
      awrite(a, {8'h00, d}, 0);
      if (legal) begin
        chk("R8 busy rises", busy, 1);
        wait_idle(cnt);
        chk("R8 write duration", cnt, WT * n);
        prog(a, {8'h00, d}, 0);
      end else begin
        chk("R9 fail set", fail, 1); chk("R9 no busy", busy, 0);
        ctl(2'd3, 8'h00);
      end
    end
    check_all("R9/R5 after sweep");

    // R5 word writes, odd address aligns down
    ctl(2'd1, 8'd8);
    for (int k = 0; k < 6; k++) begin
      int a;
      logic [15:0] d;
      a = (k * 7 + 1) % TOT;
      d = 16'hFFFF ^ (16'h0101 << k) ^ (16'h8000 >> k);
      awrite(a, d, 1);
      wait_idle(cnt);
      chk("R8 word duration", cnt, WT * 9);
      prog(a, d, 1);
    end
    check_all("R5 word program");

    // R4 block write wins over write
    ctl(2'd0, 8'h03);
    awrite(20, 16'h0F0F, 1);
    wait_idle(cnt);
    chk("R4 block duration", cnt, BT * 9);
    prog(20, 16'h0F0F, 1);
    check_all("R4 block program");

    // R10 access while busy
    ctl(2'd0, 8'h01);
    aread(0, prev);
    awrite(10, 16'h1234, 1);
    awrite(30, 16'h0000, 1);
    aread(2, v);
    chk("R10 rdata held", v, prev);
    ctl(2'd1, 8'd0);
    ctl_raw(2'd2, 16'h0001);
    wait_idle(cnt);
    prog(10, 16'h1234, 1);
    chk("R10 viol", viol, 1); chk("R10 no key_err", key_err, 0);
    chk("R10 lock kept", locked, 0);
    check_all("R10 array");
    ctl(2'd3, 8'h00);
    awrite(40, 16'h00FF, 0);
    wait_idle(cnt);
    chk("R10 divider kept", cnt, WT * 9);
    prog(40, 16'h00FF, 0);

    // R6 segment erase, erase wins over write
    ctl(2'd0, 8'h05);
    foreach (model[i]) ;
    for (int t = 0; t < 2; t++) begin
      int a;
      a = (t == 0) ? 21 : 13;
      awrite(a, 16'h0000, 0);
      wait_idle(cnt);
      chk("R8 erase duration", cnt, ET * 9);
      for (int i = 0; i < TOT; i++) if (segno(i) == segno(a)) model[i] = 8'hFF;
      check_all("R6 segment erase");
    end

    // R7 mass erase leaves info segments
    ctl(2'd0, 8'h01);
    awrite(2, 16'h0000, 1);   wait_idle(cnt); prog(2, 16'h0000, 1);
    awrite(36, 16'h0000, 1);  wait_idle(cnt); prog(36, 16'h0000, 1);
    ctl(2'd0, 8'h0C);
    awrite(3, 16'h0000, 0);
    wait_idle(cnt);
    chk("R7 mass duration", cnt, ET * 9);
    for (int i = IS*IB; i < TOT; i++) model[i] = 8'hFF;
    check_all("R7 mass erase");
    chk("R12 no stray flags", {fail, viol, key_err}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule